// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block tells a DRAM controller when to spend a command slot on a refresh. A divider produces one refresh obligation per average refresh interval. Each obligation is added to a debt counter instead of being issued at once. While the bank is serving traffic, the block waits, so refreshes can slip behind the average rate. Once the debt reaches its ceiling, the request becomes urgent and is raised even against pending accesses.

A refresh is issued when the request meets a grant from the controller's command arbiter. For the next tRFC cycles the block holds a blocking signal that keeps normal accesses off the device. The block also models the row counter that sits on the device side. That counter steps on every issued refresh and wraps back to row zero, so the controller never drives a row address. A window monitor counts issued refreshes over each retention period, which is the tick interval times the number of rows. It flags any period in which too few refreshes went out.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, debt is 0, the device row is 0, and ref_req, ref_urgent, ref_issue, access_block and window_fault are all low.
- R2: A tick is generated every TICK_CYCLES clock cycles counted from reset release, and each tick adds one to debt on the edge where it fires. The first tick is on the TICK_CYCLES-th edge.
- R3: Debt saturates at MAX_DEBT. A tick that arrives at the ceiling without a refresh in the same cycle is lost.
- R4: ref_req is high exactly when three conditions hold together: debt is non-zero, access_block is low, and either bank_busy is low or debt equals MAX_DEBT. ref_urgent is high exactly when debt equals MAX_DEBT.
- R5: ref_issue is high in a cycle where ref_req and ref_gnt are both high. Each issue removes one unit of debt, and an issue in the same cycle as a tick leaves debt unchanged.
- R6: access_block rises on the edge that takes an issue and stays high for exactly TRFC_CYCLES cycles. No request is raised while it is high.
- R7: dev_row advances by one on the edge of each issue and holds otherwise. From ROWS-1 it wraps to 0.
- R8: A retention window lasts TICK_CYCLES*ROWS cycles from reset release. At the end of each window, if fewer than ROWS-MAX_DEBT refreshes were issued in it, counting an issue on the window's last cycle, window_fault is high for the following single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_busy | input | 1 | Bank has accesses pending; non-urgent refresh waits |
| ref_gnt | input | 1 | Arbiter grants the refresh command slot |
| ref_req | output | 1 | Refresh wanted this cycle |
| ref_urgent | output | 1 | Debt at its ceiling; request overrides accesses |
| ref_issue | output | 1 | Refresh command issued this cycle |
| access_block | output | 1 | Refresh in progress; normal accesses must not be sent |
| debt | output | cw(MAX_DEBT+1) | Outstanding refresh obligations |
| dev_row | output | cw(ROWS) | Device-side refresh row pointer |
| window_fault | output | 1 | Retention window ended with too few refreshes |

## Verification
ref_req and ref_issue are combinational and are due in the same cycle as the inputs and debt that cause them. debt and dev_row change on the edge that sees the tick or the issue. access_block is due from the edge of the issue for TRFC_CYCLES cycles. window_fault follows the last edge of a window by one cycle. The bench drives inputs and samples outputs at the falling edge, and compares them with a cycle model that is stepped on the rising edge, so each result is checked in exactly the cycle the requirements place it. The stimulus covers idle and busy banks, withheld grants that saturate debt and starve a window, and a long pseudo-random pattern of busy and grant inputs.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   // Counter width for a value range of n (at least one bit)
   function automatic int cw(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Reason the request stage is in
   typedef enum logic [1:0] {
      RQ_NONE   = 2'd0,
      RQ_DEFER  = 2'd1,
      RQ_NORMAL = 2'd2,
      RQ_FORCE  = 2'd3
   } req_phase_e;

endpackage

// File: rtl/dref_tick_gen.sv
module dref_tick_gen #(
   parameter int TICK_CYCLES = 780
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = dram_ref_pkg::cw(TICK_CYCLES);

   logic [CW-1:0] cnt;

   assign tick = (cnt == CW'(TICK_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/dref_debt_ctr.sv
module dref_debt_ctr #(
   parameter int MAX_DEBT = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   tick,
   input  logic                                   issue,
   output logic [dram_ref_pkg::cw(MAX_DEBT+1)-1:0] debt,
   output logic                                   at_cap
);
   localparam int DW = dram_ref_pkg::cw(MAX_DEBT + 1);

   assign at_cap = (debt == DW'(MAX_DEBT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         unique case ({tick, issue})
            2'b10:   if (!at_cap) debt <= debt + DW'(1);
            2'b01:   debt <= debt - DW'(1);
            default: debt <= debt;
         endcase
      end
   end
endmodule

// File: rtl/dref_req_arb.sv
module dref_req_arb #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] debt,
   input  logic          at_cap,
   input  logic          bank_busy,
   input  logic          block,
   input  logic          gnt,
   output logic          req,
   output logic          issue
);
   import dram_ref_pkg::*;

   req_phase_e phase;

   always_comb begin
      if (debt == '0 || block) phase = RQ_NONE;
      else if (at_cap)         phase = RQ_FORCE;
      else if (bank_busy)      phase = RQ_DEFER;
      else                     phase = RQ_NORMAL;
   end

   assign req   = (phase == RQ_NORMAL) || (phase == RQ_FORCE);
   assign issue = req && gnt;
endmodule

// File: rtl/dref_busy_timer.sv
module dref_busy_timer #(
   parameter int TRFC_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic block
);
   localparam int BW = dram_ref_pkg::cw(TRFC_CYCLES + 1);

   logic [BW-1:0] remain;

   assign block = (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)     remain <= '0;
      else if (load)  remain <= BW'(TRFC_CYCLES);
      else if (block) remain <= remain - BW'(1);
   end
endmodule

// File: rtl/dref_row_ctr.sv
module dref_row_ctr #(
   parameter int ROWS = 8192
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              adv,
   output logic [dram_ref_pkg::cw(ROWS)-1:0] row
);
   localparam int  RW   = dram_ref_pkg::cw(ROWS);
   localparam bit  POW2 = ((ROWS & (ROWS - 1)) == 0);

   logic [RW-1:0] row_nx;

   generate
      if (POW2) begin : g_pow2_wrap
         assign row_nx = row + RW'(1);
      end else begin : g_cmp_wrap
         assign row_nx = (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   row <= '0;
      else if (adv) row <= row_nx;
   end
endmodule

// File: rtl/dref_window_mon.sv
module dref_window_mon #(
   parameter int WIN_CYCLES = 6389760,
   parameter int MIN_REFS   = 8184
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic fault
);
   localparam int PW = dram_ref_pkg::cw(WIN_CYCLES);
   localparam int CW = dram_ref_pkg::cw(WIN_CYCLES + 1);

   logic [PW-1:0] pos;
   logic [CW-1:0] refs;
   logic [CW-1:0] refs_now;
   logic          last;

   assign last     = (pos == PW'(WIN_CYCLES - 1));
   assign refs_now = refs + CW'(issue);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos   <= '0;
         refs  <= '0;
         fault <= 1'b0;
      end else begin
         pos   <= last ? '0 : pos + PW'(1);
         refs  <= last ? '0 : refs_now;
         fault <= last && (refs_now < CW'(MIN_REFS));
      end
   end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int TICK_CYCLES = 780,
   parameter int ROWS        = 8192,
   parameter int MAX_DEBT    = 8,
   parameter int TRFC_CYCLES = 8
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    bank_busy,
   input  logic                                    ref_gnt,
   output logic                                    ref_req,
   output logic                                    ref_urgent,
   output logic                                    ref_issue,
   output logic                                    access_block,
   output logic [dram_ref_pkg::cw(MAX_DEBT+1)-1:0] debt,
   output logic [dram_ref_pkg::cw(ROWS)-1:0]       dev_row,
   output logic                                    window_fault
);
   localparam int DW         = dram_ref_pkg::cw(MAX_DEBT + 1);
   localparam int WIN_CYCLES = TICK_CYCLES * ROWS;
   localparam int MIN_REFS   = ROWS - MAX_DEBT;

   generate
      if (TICK_CYCLES < 2)         begin : g_bad_tick $error("TICK_CYCLES must be at least 2"); end
      if (ROWS < 2)                begin : g_bad_rows $error("ROWS must be at least 2"); end
      if (MAX_DEBT < 1)            begin : g_bad_debt $error("MAX_DEBT must be at least 1"); end
      if (MAX_DEBT >= ROWS)        begin : g_bad_gap  $error("MAX_DEBT must be below ROWS"); end
      if (TRFC_CYCLES < 1)         begin : g_bad_trfc $error("TRFC_CYCLES must be at least 1"); end
      if (TRFC_CYCLES >= TICK_CYCLES) begin : g_bad_rate $error("TRFC_CYCLES must be below TICK_CYCLES"); end
   endgenerate

   logic tick;
   logic at_cap;

   dref_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dref_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .issue  (ref_issue),
      .debt   (debt),
      .at_cap (at_cap)
   );

   dref_req_arb #(.DW(DW)) u_arb (
      .debt      (debt),
      .at_cap    (at_cap),
      .bank_busy (bank_busy),
      .block     (access_block),
      .gnt       (ref_gnt),
      .req       (ref_req),
      .issue     (ref_issue)
   );

   dref_busy_timer #(.TRFC_CYCLES(TRFC_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ref_issue),
      .block (access_block)
   );

   dref_row_ctr #(.ROWS(ROWS)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (ref_issue),
      .row   (dev_row)
   );

   dref_window_mon #(.WIN_CYCLES(WIN_CYCLES), .MIN_REFS(MIN_REFS)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (ref_issue),
      .fault (window_fault)
   );

   assign ref_urgent = at_cap;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
   parameter int ROWS     = 8192,
   parameter int MAX_DEBT = 8
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    bank_busy,
   input logic                                    ref_req,
   input logic                                    ref_urgent,
   input logic                                    ref_issue,
   input logic                                    access_block,
   input logic [dram_ref_pkg::cw(MAX_DEBT+1)-1:0] debt,
   input logic [dram_ref_pkg::cw(ROWS)-1:0]       dev_row,
   input logic                                    window_fault
);
   localparam int DW = dram_ref_pkg::cw(MAX_DEBT + 1);
   localparam int RW = dram_ref_pkg::cw(ROWS);

   p_debt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DW'(MAX_DEBT));

   p_defer_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_busy && !ref_urgent) |-> !ref_req);

   p_urgent_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_urgent && !access_block) |-> ref_req);

   p_issue_has_debt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_issue |-> (debt != '0));

   p_issue_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_issue |=> access_block);

   p_no_req_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      access_block |-> !ref_req);

   p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_issue |=> (dev_row == (($past(dev_row) == RW'(ROWS - 1)) ? '0 : $past(dev_row) + RW'(1))));

   p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_issue |=> $stable(dev_row));

   p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      window_fault |=> !window_fault);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROWS(ROWS), .MAX_DEBT(MAX_DEBT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bank_busy    (bank_busy),
   .ref_req      (ref_req),
   .ref_urgent   (ref_urgent),
   .ref_issue    (ref_issue),
   .access_block (access_block),
   .debt         (debt),
   .dev_row      (dev_row),
   .window_fault (window_fault)
);

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
   localparam int TICK = 20;
   localparam int ROWS = 8;
   localparam int MAXD = 4;
   localparam int TRFC = 3;
   localparam int WIN  = TICK * ROWS;
   localparam int DW   = dram_ref_pkg::cw(MAXD + 1);
   localparam int RW   = dram_ref_pkg::cw(ROWS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bank_busy = 1'b0;
   logic          ref_gnt = 1'b0;
   logic          ref_req, ref_urgent, ref_issue, access_block, window_fault;
   logic [DW-1:0] debt;
   logic [RW-1:0] dev_row;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit saw_fault = 1'b0, saw_wrap = 1'b0, saw_sat = 1'b0;

   always #2.5 clk = ~clk;

   dram_refresh_sched #(.TICK_CYCLES(TICK), .ROWS(ROWS), .MAX_DEBT(MAXD), .TRFC_CYCLES(TRFC))
   u_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .bank_busy(bank_busy), .ref_gnt(ref_gnt),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_issue(ref_issue),
      .access_block(access_block), .debt(debt), .dev_row(dev_row),
      .window_fault(window_fault)
   );

   // Cycle model built from the requirements
   int m_tick, m_debt, m_busy, m_row, m_pos, m_refs;
   bit m_fault;
   bit m_req, m_issue;

   always_comb begin
      m_req   = (m_debt > 0) && (m_busy == 0) && (!bank_busy || m_debt == MAXD);
      m_issue = m_req && ref_gnt;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tick <= 0; m_debt <= 0; m_busy <= 0; m_row <= 0;
         m_pos <= 0; m_refs <= 0; m_fault <= 1'b0;
      end else begin
         automatic bit tk  = (m_tick == TICK - 1);
         automatic bit lst = (m_pos == WIN - 1);
         automatic int rn  = m_refs + (m_issue ? 1 : 0);
         m_tick <= tk ? 0 : m_tick + 1;
         if (tk && !m_issue)      m_debt <= (m_debt < MAXD) ? m_debt + 1 : MAXD;
         else if (!tk && m_issue) m_debt <= m_debt - 1;
         m_busy  <= m_issue ? TRFC : (m_busy > 0 ? m_busy - 1 : 0);
         if (m_issue) m_row <= (m_row + 1) % ROWS;
         m_pos   <= lst ? 0 : m_pos + 1;
         m_refs  <= lst ? 0 : rn;
         m_fault <= lst && (rn < ROWS - MAXD);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2 R3 R5 debt", int'(debt), m_debt);
      chk("R4 ref_req", int'(ref_req), int'(m_req));
      chk("R4 ref_urgent", int'(ref_urgent), (m_debt == MAXD) ? 1 : 0);
      chk("R5 ref_issue", int'(ref_issue), int'(m_issue));
      chk("R6 access_block", int'(access_block), (m_busy != 0) ? 1 : 0);
      chk("R7 dev_row", int'(dev_row), m_row);
      chk("R8 window_fault", int'(window_fault), int'(m_fault));
      if (window_fault) saw_fault = 1'b1;
      if (ref_issue && dev_row == RW'(ROWS - 1)) saw_wrap = 1'b1;
      if (debt == DW'(MAXD)) saw_sat = 1'b1;
   endtask

   task automatic run(input int n, input bit busy, input bit gnt);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         bank_busy = busy;
         ref_gnt   = gnt;
      end
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 debt", int'(debt), 0);
      chk("R1 dev_row", int'(dev_row), 0);
      chk("R1 ref_req", int'(ref_req), 0);
      chk("R1 ref_urgent", int'(ref_urgent), 0);
      chk("R1 ref_issue", int'(ref_issue), 0);
      chk("R1 access_block", int'(access_block), 0);
      chk("R1 window_fault", int'(window_fault), 0);
      rst_n = 1'b1;
      run(200, 1'b0, 1'b1);   // idle bank, prompt grant
      run(220, 1'b1, 1'b0);   // busy, no grant: debt saturates
      run(80,  1'b1, 1'b1);   // busy, urgent refreshes only
      run(400, 1'b0, 1'b0);   // starved windows
      for (int i = 0; i < 700; i++) begin
         @(negedge clk);
         compare_all();
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         bank_busy = lfsr[0] | lfsr[1];
         ref_gnt   = lfsr[2] | lfsr[3];
      end
      run(250, 1'b0, 1'b1);
      chk("R3 saturation reached", int'(saw_sat), 1);
      chk("R7 wrap observed", int'(saw_wrap), 1);
      chk("R8 fault observed", int'(saw_fault), 1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule